// File: doc/BRIEF.md
# Byte Program Retry Sequencer

This block runs a one-time-programmable memory array through a programming pass, one byte at a time. After a start command it walks the addresses upward from zero. For each byte it places the wanted data on the memory's data pins and raises the program-voltage enable. It then gives a chip-enable pulse of fixed width. After that it drops the program voltage and reads the byte back with chip enable and output enable low. If the read-back byte differs from the wanted byte, it pulses again. A byte that still fails after the allowed number of pulses stops the whole run.

When the last byte has verified, the block makes one more pass over the whole array in read mode. It compares every byte with the source data. Completion is reported with a done flag and a pass flag, and on failure the address of the first bad byte is held. The wanted data comes from an external source that is addressed by byte and answers combinationally.

All waits are given in nanoseconds together with the clock frequency in MHz, and each one is rounded up to whole clock cycles. The supply rails themselves are not controlled here. Only the program-voltage enable and the data-drive enable leave the block.

Top module: `prog_retry_seq`

## Requirements
- R1: After reset the block is idle: `prom_ce_n`=1, `prom_oe_n`=1, `prom_vpp_en`=0, `prom_d_oe`=0, `busy`=0, `done`=0, `pass`=0.
- R2: Every program pulse holds `prom_ce_n` low, with `prom_vpp_en` and `prom_d_oe` high, for exactly ceil(PULSE_NS*CLK_MHZ/1000) cycles.
- R3: `prom_vpp_en` and `prom_d_oe` rise together. They stay high, with `prom_ce_n` high, for exactly ceil(SETUP_NS*CLK_MHZ/1000) cycles before each pulse. After the pulse they stay high for exactly ceil(HOLD_NS*CLK_MHZ/1000) cycles. `prom_addr` and `prom_d` do not change while `prom_vpp_en` is high.
- R4: After the hold time, the program voltage and the data drive turn off and a verify read runs. It lasts ceil(VRFY_NS*CLK_MHZ/1000) cycles with `prom_ce_n` and `prom_oe_n` low. In its last cycle `prom_q` is compared with `src_data`, and `src_addr` equals `prom_addr`.
- R5: `prom_ce_n` never rises during a run while `prom_vpp_en` is low, so chip enable stays low through a whole verify read. `prom_oe_n` is low only while `prom_ce_n` is low and both `prom_vpp_en` and `prom_d_oe` are low.
- R6: A verify mismatch starts another pulse at the same address. The attempt count is cleared at every new address, so a byte that first verifies after N pulses (N ≤ MAX_TRY) receives exactly N pulses.
- R7: If the verify after the MAX_TRY-th pulse of a byte fails, the run stops: `done`=1, `pass`=0, `fail_addr` is that address, all enables are deasserted, and no later address is pulsed. A match on the MAX_TRY-th verify continues normally.
- R8: Bytes are programmed in ascending address order from 0 to DEPTH-1. Each byte passes verify before the next one is pulsed.
- R9: After the last byte, every address from 0 to DEPTH-1 is read again with the program voltage off, for ceil(READ_NS*CLK_MHZ/1000) cycles each. The first mismatch ends the run with `pass`=0 and `fail_addr` set to that address. If every byte matches, the run ends with `pass`=1.
- R10: `start` is acted on only while `busy`=0, and then clears `done` and `pass`. A `start` during a run has no effect on it.
- R11: `done`, `pass` and `fail_addr` hold their values, and the block stays idle, until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a programming run (sampled while idle) |
| src_data | input | DATA_W | Wanted byte at `src_addr` |
| prom_q | input | DATA_W | Data read from the target array |
| src_addr | output | ADDR_W | Address presented to the data source |
| prom_addr | output | ADDR_W | Address driven to the target array |
| prom_d | output | DATA_W | Data driven to the target array |
| prom_d_oe | output | 1 | Data pins driven while high |
| prom_ce_n | output | 1 | Chip enable to the target, active low |
| prom_oe_n | output | 1 | Output enable / read strobe to the target, active low |
| prom_vpp_en | output | 1 | Program-voltage enable |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has finished |
| pass | output | 1 | The last run finished without error |
| fail_addr | output | ADDR_W | Address that ended a failed run |

## Verification
In one cycle, a verify decision can see the attempt count at its limit, a matching byte, and the last address all at the same time. In that case the match must win, and the sequencer must move into the final compare pass rather than failing. The bench forces this by making the top address accept data only on its MAX_TRY-th pulse. It then expects exactly MAX_TRY pulses at that address and a passing result. The opposite case is a byte that never accepts its data. There the bench expects a failure at that address after exactly MAX_TRY pulses, and no pulse at any higher address.

// File: rtl/prs_pkg.sv
package prs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_PULSE,
      ST_HOLD,
      ST_VRFY,
      ST_CMP
   } prs_state_e;

   // Convert a wait in ns to clock cycles, rounding up, never below one.
   function automatic int unsigned ns_to_cyc(input int unsigned ns,
                                             input int unsigned mhz);
      longint unsigned prod;
      longint unsigned cyc;
      prod = longint'(ns) * longint'(mhz);
      cyc  = (prod + 64'd999) / 64'd1000;
      if (cyc == 0) cyc = 1;
      return int'(cyc);
   endfunction

endpackage

// File: rtl/prs_timer.sv
module prs_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/prs_retry.sv
module prs_retry #(
   parameter int MAX_TRY = 25,
   parameter int TRY_W   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [TRY_W-1:0] tries,
   output logic             at_limit
);

   logic [TRY_W-1:0] tries_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tries_q <= '0;
      end else if (clr) begin
         tries_q <= '0;
      end else if (inc && (tries_q != TRY_W'(MAX_TRY))) begin
         tries_q <= tries_q + 1'b1;
      end
   end

   assign tries    = tries_q;
   assign at_limit = (tries_q == TRY_W'(MAX_TRY));

endmodule

// File: rtl/prs_addr.sv
module prs_addr #(
   parameter int ADDR_W = 16,
   parameter int DEPTH  = 65536
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              step,
   output logic [ADDR_W-1:0] addr,
   output logic              is_last
);

   localparam longint FULL = longint'(1) << ADDR_W;

   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (clr) begin
         addr_q <= '0;
      end else if (step) begin
         addr_q <= addr_q + 1'b1;
      end
   end

   generate
      if (longint'(DEPTH) == FULL) begin : g_full_span
         assign is_last = &addr_q;
      end else begin : g_part_span
         assign is_last = (addr_q == ADDR_W'(DEPTH - 1));
      end
   endgenerate

   assign addr = addr_q;

endmodule

// File: rtl/prog_retry_seq.sv
module prog_retry_seq
   import prs_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DEPTH    = 65536,
   parameter int DATA_W   = 8,
   parameter int MAX_TRY  = 25,
   parameter int CLK_MHZ  = 50,
   parameter int PULSE_NS = 100000,
   parameter int SETUP_NS = 2000,
   parameter int HOLD_NS  = 2000,
   parameter int VRFY_NS  = 2000,
   parameter int READ_NS  = 200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] src_data,
   input  logic [DATA_W-1:0] prom_q,
   output logic [ADDR_W-1:0] src_addr,
   output logic [ADDR_W-1:0] prom_addr,
   output logic [DATA_W-1:0] prom_d,
   output logic              prom_d_oe,
   output logic              prom_ce_n,
   output logic              prom_oe_n,
   output logic              prom_vpp_en,
   output logic              busy,
   output logic              done,
   output logic              pass,
   output logic [ADDR_W-1:0] fail_addr
);

   localparam int unsigned PULSE_CYC = ns_to_cyc(PULSE_NS, CLK_MHZ);
   localparam int unsigned SETUP_CYC = ns_to_cyc(SETUP_NS, CLK_MHZ);
   localparam int unsigned HOLD_CYC  = ns_to_cyc(HOLD_NS,  CLK_MHZ);
   localparam int unsigned VRFY_CYC  = ns_to_cyc(VRFY_NS,  CLK_MHZ);
   localparam int unsigned READ_CYC  = ns_to_cyc(READ_NS,  CLK_MHZ);
   localparam int unsigned MAX_A     = (PULSE_CYC > SETUP_CYC) ? PULSE_CYC : SETUP_CYC;
   localparam int unsigned MAX_B     = (HOLD_CYC  > VRFY_CYC)  ? HOLD_CYC  : VRFY_CYC;
   localparam int unsigned MAX_C     = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int unsigned MAX_CYC   = (MAX_C > READ_CYC) ? MAX_C : READ_CYC;
   localparam int          CNT_W     = $clog2(MAX_CYC + 1);
   localparam int          TRY_W     = $clog2(MAX_TRY + 1);

   // elaboration-time parameter checks
   generate
      if (ADDR_W < 1 || ADDR_W > 30) begin : g_bad_addr_w
         $error("prog_retry_seq: ADDR_W out of range");
      end
      if (DEPTH < 1 || longint'(DEPTH) > (longint'(1) << ADDR_W)) begin : g_bad_depth
         $error("prog_retry_seq: DEPTH does not fit ADDR_W");
      end
      if (DATA_W < 1) begin : g_bad_data_w
         $error("prog_retry_seq: DATA_W must be positive");
      end
      if (MAX_TRY < 1) begin : g_bad_try
         $error("prog_retry_seq: MAX_TRY must be positive");
      end
      if (CLK_MHZ < 1) begin : g_bad_clk
         $error("prog_retry_seq: CLK_MHZ must be positive");
      end
   endgenerate

   prs_state_e         st_q, st_d;
   logic               t_load;
   logic [CNT_W-1:0]   t_val;
   logic               t_exp;
   logic               try_clr, try_inc, try_lim;
   logic [TRY_W-1:0]   tries;
   logic               a_clr, a_step, a_last;
   logic [ADDR_W-1:0]  addr;
   logic               go, fin_ok, fin_bad;
   logic               byte_ok;
   logic               done_q, pass_q;
   logic [ADDR_W-1:0]  fail_q;

   prs_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .expired  (t_exp)
   );

   prs_retry #(.MAX_TRY(MAX_TRY), .TRY_W(TRY_W)) u_retry (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (try_clr),
      .inc      (try_inc),
      .tries    (tries),
      .at_limit (try_lim)
   );

   prs_addr #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (a_clr),
      .step    (a_step),
      .addr    (addr),
      .is_last (a_last)
   );

   assign byte_ok = (prom_q == src_data);

   always_comb begin
      st_d    = st_q;
      t_load  = 1'b0;
      t_val   = '0;
      try_clr = 1'b0;
      try_inc = 1'b0;
      a_clr   = 1'b0;
      a_step  = 1'b0;
      go      = 1'b0;
      fin_ok  = 1'b0;
      fin_bad = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (start) begin
               go      = 1'b1;
               a_clr   = 1'b1;
               try_clr = 1'b1;
               t_load  = 1'b1;
               t_val   = CNT_W'(SETUP_CYC - 1);
               st_d    = ST_SETUP;
            end
         end
         ST_SETUP: begin
            if (t_exp) begin
               t_load = 1'b1;
               t_val  = CNT_W'(PULSE_CYC - 1);
               st_d   = ST_PULSE;
            end
         end
         ST_PULSE: begin
            if (t_exp) begin
               try_inc = 1'b1;
               t_load  = 1'b1;
               t_val   = CNT_W'(HOLD_CYC - 1);
               st_d    = ST_HOLD;
            end
         end
         ST_HOLD: begin
            if (t_exp) begin
               t_load = 1'b1;
               t_val  = CNT_W'(VRFY_CYC - 1);
               st_d   = ST_VRFY;
            end
         end
         ST_VRFY: begin
            if (t_exp) begin
               if (byte_ok) begin
                  try_clr = 1'b1;
                  t_load  = 1'b1;
                  if (a_last) begin
                     a_clr = 1'b1;
                     t_val = CNT_W'(READ_CYC - 1);
                     st_d  = ST_CMP;
                  end else begin
                     a_step = 1'b1;
                     t_val  = CNT_W'(SETUP_CYC - 1);
                     st_d   = ST_SETUP;
                  end
               end else if (try_lim) begin
                  fin_bad = 1'b1;
                  st_d    = ST_IDLE;
               end else begin
                  t_load = 1'b1;
                  t_val  = CNT_W'(SETUP_CYC - 1);
                  st_d   = ST_SETUP;
               end
            end
         end
         ST_CMP: begin
            if (t_exp) begin
               if (!byte_ok) begin
                  fin_bad = 1'b1;
                  st_d    = ST_IDLE;
               end else if (a_last) begin
                  fin_ok = 1'b1;
                  st_d   = ST_IDLE;
               end else begin
                  a_step = 1'b1;
                  t_load = 1'b1;
                  t_val  = CNT_W'(READ_CYC - 1);
               end
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         done_q <= 1'b0;
         pass_q <= 1'b0;
         fail_q <= '0;
      end else begin
         st_q <= st_d;
         if (go) begin
            done_q <= 1'b0;
            pass_q <= 1'b0;
            fail_q <= '0;
         end else if (fin_ok) begin
            done_q <= 1'b1;
            pass_q <= 1'b1;
         end else if (fin_bad) begin
            done_q <= 1'b1;
            pass_q <= 1'b0;
            fail_q <= addr;
         end
      end
   end

   // pin levels decoded straight from the phase register
   assign prom_vpp_en = (st_q == ST_SETUP) || (st_q == ST_PULSE) || (st_q == ST_HOLD);
   assign prom_d_oe   = prom_vpp_en;
   assign prom_ce_n   = !((st_q == ST_PULSE) || (st_q == ST_VRFY) || (st_q == ST_CMP));
   assign prom_oe_n   = !((st_q == ST_VRFY) || (st_q == ST_CMP));
   assign prom_addr   = addr;
   assign src_addr    = addr;
   assign prom_d      = src_data;
   assign busy        = (st_q != ST_IDLE);
   assign done        = done_q;
   assign pass        = pass_q;
   assign fail_addr   = fail_q;

endmodule

// File: rtl/prs_chk.sv
module prs_chk
   import prs_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 8,
   parameter int MAX_TRY  = 25,
   parameter int CLK_MHZ  = 50,
   parameter int PULSE_NS = 100000,
   parameter int SETUP_NS = 2000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              prom_ce_n,
   input logic              prom_oe_n,
   input logic              prom_vpp_en,
   input logic              prom_d_oe,
   input logic [ADDR_W-1:0] prom_addr,
   input logic [DATA_W-1:0] prom_d
);

   localparam int unsigned PULSE_CYC = ns_to_cyc(PULSE_NS, CLK_MHZ);
   localparam int unsigned SETUP_CYC = ns_to_cyc(SETUP_NS, CLK_MHZ);

   logic              pulse, pulse_q;
   int unsigned       plen, scnt, npulse;
   logic [ADDR_W-1:0] last_a;

   assign pulse = !prom_ce_n && prom_vpp_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse_q <= 1'b0;
         plen    <= 0;
         scnt    <= 0;
         npulse  <= 0;
         last_a  <= '0;
      end else begin
         pulse_q <= pulse;
         plen    <= pulse ? plen + 1 : 0;
         if (!prom_vpp_en) scnt <= 0;
         else if (prom_ce_n) scnt <= scnt + 1;
         if (!busy) begin
            npulse <= 0;
         end else if (pulse && !pulse_q) begin
            npulse <= (prom_addr == last_a) ? npulse + 1 : 1;
            last_a <= prom_addr;
         end
      end
   end

   a_r2_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_q && !pulse) |-> (plen == PULSE_CYC));

   a_r3_setup_before_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse && !pulse_q) |-> (scnt == SETUP_CYC));

   a_r3_steady_while_vpp: assert property (@(posedge clk) disable iff (!rst_n)
      (prom_vpp_en && $past(prom_vpp_en)) |-> ($stable(prom_addr) && $stable(prom_d)));

   a_r5_read_bus_free: assert property (@(posedge clk) disable iff (!rst_n)
      !prom_oe_n |-> (!prom_ce_n && !prom_vpp_en && !prom_d_oe));

   a_r5_ce_low_until_vpp: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $rose(prom_ce_n)) |-> prom_vpp_en);

   a_r6_try_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && pulse && !pulse_q && (prom_addr == last_a)) |-> (npulse < MAX_TRY));

   a_r7_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (prom_ce_n && prom_oe_n && !prom_vpp_en && !prom_d_oe && !busy));

endmodule

bind prog_retry_seq prs_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .MAX_TRY  (MAX_TRY),
   .CLK_MHZ  (CLK_MHZ),
   .PULSE_NS (PULSE_NS),
   .SETUP_NS (SETUP_NS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .busy        (busy),
   .done        (done),
   .prom_ce_n   (prom_ce_n),
   .prom_oe_n   (prom_oe_n),
   .prom_vpp_en (prom_vpp_en),
   .prom_d_oe   (prom_d_oe),
   .prom_addr   (prom_addr),
   .prom_d      (prom_d)
);

// File: tb/prog_retry_seq_tb.sv
`timescale 1ns/1ps
module prog_retry_seq_tb;

   localparam int AW    = 3;
   localparam int DEPTH = 8;
   localparam int DW    = 8;
   localparam int MAXT  = 25;
   // 250 MHz: 40 ns -> 10 cycles, 10 ns -> 3 cycles (2.5 rounded up), 6 ns -> 2
   localparam int PC = 10;
   localparam int SC = 3;
   localparam int HC = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [DW-1:0] src_data, prom_q, prom_d;
   logic [AW-1:0] src_addr, prom_addr, fail_addr;
   logic          prom_d_oe, prom_ce_n, prom_oe_n, prom_vpp_en, busy, done, pass;

   logic [DW-1:0] mem [DEPTH];
   logic [DW-1:0] src_mem [DEPTH];
   int            need [DEPTH];
   int            pcnt [DEPTH];
   bit            dist_on;
   int            dist_src, dist_vic;
   int            nvec = 0;
   int            nbad = 0;
   bit            wd = 1'b0;

   always #2 clk = ~clk;

   assign prom_q   = mem[prom_addr];
   assign src_data = src_mem[src_addr];

   prog_retry_seq #(
      .ADDR_W(AW), .DEPTH(DEPTH), .DATA_W(DW), .MAX_TRY(MAXT), .CLK_MHZ(250),
      .PULSE_NS(40), .SETUP_NS(10), .HOLD_NS(10), .VRFY_NS(10), .READ_NS(6)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .src_data(src_data), .prom_q(prom_q),
      .src_addr(src_addr), .prom_addr(prom_addr), .prom_d(prom_d), .prom_d_oe(prom_d_oe),
      .prom_ce_n(prom_ce_n), .prom_oe_n(prom_oe_n), .prom_vpp_en(prom_vpp_en),
      .busy(busy), .done(done), .pass(pass), .fail_addr(fail_addr)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      nvec++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // watches the pins at negedge and models the target array
   task automatic monitor();
      bit prev_p = 0, prev_vpp = 0, prev_ce = 1, after_p = 0, steady = 1;
      int plen = 0, scnt = 0, hcnt = 0, last_a = -1;
      logic [AW-1:0] la;
      logic [DW-1:0] ld;
      forever begin
         @(negedge clk);
         begin
            bit cur_p;
            cur_p = !prom_ce_n && prom_vpp_en;
            if (!busy) last_a = -1;
            if (prom_vpp_en && !prev_vpp) begin
               la = prom_addr; ld = prom_d; steady = 1;
            end
            if (prom_vpp_en && (prom_addr !== la || prom_d !== ld || !prom_d_oe)) steady = 0;
            if (cur_p && !prev_p) begin
               chk(scnt == SC, "R3", "setup cycles", scnt, SC);
               if (last_a >= 0)
                  chk(int'(prom_addr) == last_a || int'(prom_addr) == last_a + 1,
                      "R8", "address order", prom_addr, last_a + 1);
               last_a = prom_addr;
               plen = 0;
            end
            if (cur_p) plen++;
            if (!cur_p && prev_p) begin
               chk(plen == PC, "R2", "pulse width", plen, PC);
               pcnt[prom_addr]++;
               if (pcnt[prom_addr] >= need[prom_addr])
                  mem[prom_addr] = mem[prom_addr] & prom_d;
               if (dist_on && int'(prom_addr) == dist_src)
                  mem[dist_vic] = mem[dist_vic] & ~8'h01;
               after_p = 1; hcnt = 0;
            end
            if (!prom_vpp_en) scnt = 0;
            else if (prom_ce_n && !after_p) scnt++;
            if (prom_vpp_en && prom_ce_n && after_p) hcnt++;
            if (!prom_vpp_en && prev_vpp) begin
               if (after_p) chk(hcnt == HC, "R3", "hold cycles", hcnt, HC);
               chk(steady, "R3", "addr/data steady under vpp", steady, 1);
               after_p = 0;
            end
            if (busy && prom_ce_n && !prev_ce && !prom_vpp_en)
               chk(0, "R5", "ce rose with vpp off", 1, 0);
            if (!prom_oe_n && (prom_ce_n || prom_vpp_en || prom_d_oe))
               chk(0, "R5", "read strobe with bus driven", 1, 0);
            prev_p = cur_p; prev_vpp = prom_vpp_en; prev_ce = prom_ce_n;
         end
      end
   endtask

   task automatic prep(input bit rnd_need);
      for (int a = 0; a < DEPTH; a++) begin
         mem[a]     = 8'hFF;
         src_mem[a] = 8'($urandom);
         need[a]    = rnd_need ? $urandom_range(1, MAXT) : 1;
         pcnt[a]    = 0;
      end
      dist_on = 0;
   endtask

   task automatic kick();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic wait_done();
      int n = 0;
      while (!done && n < 30000) begin @(negedge clk); n++; end
      chk(done, "R9", "run finished", done, 1);
   endtask

   task automatic expect_pulses(input string req);
      for (int a = 0; a < DEPTH; a++)
         chk(pcnt[a] == need[a], req, "pulses per byte", pcnt[a], need[a]);
   endtask

   initial begin
      void'($urandom(32'd7351));
      prep(0);
      fork monitor(); join_none
      fork
         begin
            repeat (3) @(negedge clk);
            // R1 reset state
            chk(prom_ce_n && prom_oe_n && !prom_vpp_en && !prom_d_oe,
                "R1", "enables at reset", {prom_ce_n, prom_oe_n, prom_vpp_en, prom_d_oe}, 4'b1100);
            chk(!busy && !done && !pass, "R1", "status at reset", {busy, done, pass}, 0);
            rst_n = 1'b1;
            repeat (2) @(negedge clk);

            // plain runs, random data, every byte takes on its first pulse
            for (int k = 0; k < 3; k++) begin
               prep(0);
               kick();
               chk(busy && !done, "R10", "start accepted", {busy, done}, 2);
               wait_done();
               chk(pass, "R9", "clean run passes", pass, 1);
               expect_pulses("R8");
            end

            // retries: random pulse needs, top byte needs exactly MAXT
            // (verify match coincides with attempt limit on the last address)
            prep(1);
            need[DEPTH-1] = MAXT;
            kick();
            repeat (300) @(negedge clk);
            start = 1'b1; @(negedge clk); start = 1'b0;   // ignored mid-run
            wait_done();
            chk(pass, "R7", "match on last attempt passes", pass, 1);
            expect_pulses("R6");
            chk(pcnt[DEPTH-1] == MAXT, "R4", "verify reads at top byte", pcnt[DEPTH-1], MAXT);

            // a byte that can never verify
            prep(0);
            mem[5] = 8'h00; src_mem[5] = 8'hA5;
            kick();
            wait_done();
            chk(!pass, "R7", "stuck byte fails", pass, 0);
            chk(fail_addr == 3'd5, "R7", "fail address", fail_addr, 5);
            chk(pcnt[5] == MAXT, "R7", "pulses on stuck byte", pcnt[5], MAXT);
            chk(pcnt[6] == 0 && pcnt[7] == 0, "R7", "no pulses above", pcnt[6] + pcnt[7], 0);
            repeat (40) @(negedge clk);
            chk(done && !pass && fail_addr == 3'd5, "R11", "result held", fail_addr, 5);
            chk(prom_ce_n && prom_oe_n && !prom_vpp_en && !busy, "R11", "stays idle", busy, 0);

            // programming byte 6 disturbs byte 2: caught only by final compare
            prep(0);
            src_mem[2] = src_mem[2] | 8'h01;
            dist_on = 1; dist_src = 6; dist_vic = 2;
            kick();
            chk(!done, "R10", "start clears done", done, 0);
            wait_done();
            chk(!pass, "R9", "final compare fails", pass, 0);
            chk(fail_addr == 3'd2, "R9", "final compare address", fail_addr, 2);
            expect_pulses("R9");
         end
         begin
            repeat (150000) @(posedge clk);
            wd = 1'b1;
         end
      join_any
      disable fork;
      if (wd) chk(0, "R9", "watchdog expired", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

endmodule